// File: doc/BRIEF.md
# NOP Injection and Reset-Vector Override Unit

This unit sits on the data path between an 8-bit CPU, the onboard SRAM and the transceiver that leads to the mainboard. It is used for bus diagnostics. When a microcontroller asks for NOP mode, the unit cuts off both memory paths. It then answers every CPU read with the single-byte no-operation opcode 8'hEA. The CPU executes that opcode over and over, so its program counter sweeps the entire 64 KiB space without stopping. The sweep includes the I/O window, where real peripherals could otherwise hold the bus. This produces clean square waves on the address lines, which can be probed with a scope.

The same data-injection path can also return a chosen 16-bit jump target in place of the reset vector. The microcontroller loads the target word and holds the CPU in reset with the override enabled. On the first vector fetch after reset is released, the unit answers the two vector reads itself. After that it steps aside.

Outside these two overrides, the memory selects coming from the address mapper upstream pass through unchanged, and the unit does not drive the data bus.

Top module: `nop_inject_unit`

## Requirements
- R1: While NOP mode is active and no vector override applies, every read cycle (`cpu_rw`=1) drives `cpu_doe`=1 with `cpu_dout`=8'hEA.
- R2: While NOP mode is active, `sram_sel` and `xcvr_en` are both 0 on every cycle, for reads and writes at any address, including the I/O window 16'hE800–16'hEFFF.
- R3: During NOP-mode write cycles (`cpu_rw`=0), `cpu_doe`=0 and `cpu_dout`=0.
- R4: `nop_req` is sampled on the rising clock edge. The mode seen in a cycle is the request level captured at the previous edge, so the mode never changes part-way through a cycle.
- R5: The load strobe `vec_load` stores `vec_word` at the next edge. While the override is armed and the CPU is out of reset, a read of 16'hFFFC returns `vec_word[7:0]` and a read of 16'hFFFD returns `vec_word[15:8]`, with `cpu_doe`=1.
- R6: The override is armed at each edge where `cpu_reset`=1 and `vec_enable`=1; an edge with `cpu_reset`=1 and `vec_enable`=0 disarms it. After reset is released, it disarms at the edge that ends the first read of 16'hFFFD, and later vector reads pass through.
- R7: An armed vector read takes precedence over NOP mode. During it, `sram_sel` and `xcvr_en` are both 0.
- R8: With NOP mode off and no vector override, `sram_sel` follows `sram_sel_in`, `xcvr_en` follows `xcvr_en_in`, `cpu_doe`=0 and `cpu_dout`=0.
- R9: Synchronous reset `rst` leaves NOP mode off, the override disarmed and the stored vector at 0.
- R10: Writes to 16'hFFFC or 16'hFFFD while armed are not overridden and do not disarm the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; one bus cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| nop_req | input | 1 | NOP mode request from the microcontroller |
| vec_enable | input | 1 | Arms the vector override while the CPU is held in reset |
| vec_load | input | 1 | Load strobe for the jump target |
| vec_word | input | 16 | Jump target word |
| cpu_reset | input | 1 | CPU reset line, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| sram_sel_in | input | 1 | SRAM select from the upstream mapper |
| xcvr_en_in | input | 1 | Transceiver enable from the upstream mapper |
| cpu_dout | output | 8 | Injected data byte |
| cpu_doe | output | 1 | Drive enable for the injected byte |
| sram_sel | output | 1 | SRAM select to the memory |
| xcvr_en | output | 1 | Transceiver enable to the mainboard |

## Verification
The bench steps NOP mode on and off in the middle of runs. A design that does not register the request would change the opcode within the cycle of the request, or one cycle late, instead of from the next cycle on.

Reads and writes are swept through the I/O window with NOP on. Leaking either select there would connect the mainboard, and driving during a write would cause bus contention.

Vector fetches are exercised in several situations:
- repeated FFFC reads;
- writes to the vector addresses while armed;
- NOP mode active at the same time;
- a reset held with the enable low.

A design that disarmed on the low byte, on a write, or never disarmed would return the wrong high byte or would keep overriding later fetches.

// File: rtl/nopgen_pkg.sv
package nopgen_pkg;

    localparam int          ADDR_W     = 16;
    localparam int          DATA_W     = 8;
    localparam logic [7:0]  NOP_OPCODE = 8'hEA;
    localparam logic [15:0] VEC_BASE   = 16'hFFFC;

    // Which party owns the data path in the current bus cycle
    typedef enum logic [1:0] {
        SRC_PASS   = 2'd0,
        SRC_NOP    = 2'd1,
        SRC_VECTOR = 2'd2
    } src_e;

    // Memory-path selects travelling together
    typedef struct packed {
        logic sram;
        logic xcvr;
    } sel_t;

    // Vector answer outranks NOP injection, which outranks pass-through
    function automatic src_e pick_source(input logic vec_hit, input logic nop_on);
        if (vec_hit)     return SRC_VECTOR;
        else if (nop_on) return SRC_NOP;
        else             return SRC_PASS;
    endfunction

endpackage

// File: rtl/nopgen_mode_reg.sv
module nopgen_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic nop_req,
    output logic nop_on
);

    // Request captured at a clock edge only, so a cycle sees one mode
    always_ff @(posedge clk) begin
        if (rst) nop_on <= 1'b0;
        else     nop_on <= nop_req;
    end

endmodule

// File: rtl/nopgen_vector_unit.sv
module nopgen_vector_unit #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vec_load,
    input  logic [2*DATA_W-1:0]   vec_word,
    input  logic                  vec_enable,
    input  logic                  cpu_reset,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_rw,
    output logic                  vec_hit,
    output logic [DATA_W-1:0]     vec_byte,
    output logic                  armed
);

    localparam int VEC_BYTES = 2;
    localparam int VW        = VEC_BYTES * DATA_W;

    logic [VW-1:0]     vec_q;
    logic [DATA_W-1:0] byte_lane [VEC_BYTES];
    logic              in_window;
    logic              last_byte;

    for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
        assign byte_lane[g] = vec_q[g*DATA_W +: DATA_W];
    end

    // Vector pair occupies an even/odd address couple
    assign in_window = (cpu_addr[ADDR_W-1:1] == VEC_BASE[ADDR_W-1:1]);
    assign last_byte = cpu_addr[0];
    assign vec_hit   = armed & ~cpu_reset & cpu_rw & in_window;
    assign vec_byte  = byte_lane[last_byte];

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            armed <= 1'b0;
        end else begin
            if (vec_load)
                vec_q <= vec_word;
            if (cpu_reset)
                armed <= vec_enable;
            else if (vec_hit && last_byte)
                armed <= 1'b0;
        end
    end

endmodule

// File: rtl/nopgen_bus_steer.sv
module nopgen_bus_steer
    import nopgen_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] NOP_CODE = 8'hEA
) (
    input  src_e              src,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] vec_byte,
    input  sel_t              sel_in,
    output sel_t              sel_out,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);

    always_comb begin
        sel_out = '0;
        dout    = '0;
        doe     = 1'b0;
        unique case (src)
            SRC_VECTOR: begin
                doe  = 1'b1;
                dout = vec_byte;
            end
            SRC_NOP: begin
                // Released during writes so the CPU owns the bus
                doe  = cpu_rw;
                dout = cpu_rw ? NOP_CODE : '0;
            end
            default: begin
                sel_out = sel_in;
            end
        endcase
    end

endmodule

// File: rtl/nop_inject_unit.sv
module nop_inject_unit
    import nopgen_pkg::*;
#(
    parameter int                ADDR_W   = nopgen_pkg::ADDR_W,
    parameter int                DATA_W   = nopgen_pkg::DATA_W,
    parameter logic [DATA_W-1:0] NOP_CODE = nopgen_pkg::NOP_OPCODE,
    parameter logic [ADDR_W-1:0] VEC_BASE = nopgen_pkg::VEC_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nop_req,
    input  logic                vec_enable,
    input  logic                vec_load,
    input  logic [2*DATA_W-1:0] vec_word,
    input  logic                cpu_reset,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rw,
    input  logic                sram_sel_in,
    input  logic                xcvr_en_in,
    output logic [DATA_W-1:0]   cpu_dout,
    output logic                cpu_doe,
    output logic                sram_sel,
    output logic                xcvr_en
);

    logic              nop_on;
    logic              armed;
    logic              vec_hit;
    logic [DATA_W-1:0] vec_byte;
    src_e              src;
    sel_t              sel_in;
    sel_t              sel_out;

    nopgen_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .nop_req (nop_req),
        .nop_on  (nop_on)
    );

    nopgen_vector_unit #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .clk        (clk),
        .rst        (rst),
        .vec_load   (vec_load),
        .vec_word   (vec_word),
        .vec_enable (vec_enable),
        .cpu_reset  (cpu_reset),
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .vec_hit    (vec_hit),
        .vec_byte   (vec_byte),
        .armed      (armed)
    );

    assign src         = pick_source(vec_hit, nop_on);
    assign sel_in.sram = sram_sel_in;
    assign sel_in.xcvr = xcvr_en_in;

    nopgen_bus_steer #(
        .DATA_W   (DATA_W),
        .NOP_CODE (NOP_CODE)
    ) u_steer (
        .src      (src),
        .cpu_rw   (cpu_rw),
        .vec_byte (vec_byte),
        .sel_in   (sel_in),
        .sel_out  (sel_out),
        .dout     (cpu_dout),
        .doe      (cpu_doe)
    );

    assign sram_sel = sel_out.sram;
    assign xcvr_en  = sel_out.xcvr;

endmodule

// File: rtl/nop_inject_unit_chk.sv
module nop_inject_unit_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] NOP_CODE = 8'hEA,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
    input logic              clk,
    input logic              rst,
    input logic              nop_req,
    input logic              cpu_reset,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              sram_sel_in,
    input logic              xcvr_en_in,
    input logic [DATA_W-1:0] cpu_dout,
    input logic              cpu_doe,
    input logic              sram_sel,
    input logic              xcvr_en,
    input logic              nop_on,
    input logic              armed,
    input logic              vec_hit
);

    localparam logic [ADDR_W-1:0] VEC_HI = VEC_BASE + 1'b1;

    logic seen_rst;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    AST_NOP_READ_OPCODE: assert property (@(posedge clk) disable iff (rst)
        seen_rst && nop_on && cpu_rw && !vec_hit |-> cpu_doe && cpu_dout == NOP_CODE); // R1

    AST_NOP_PATHS_OFF: assert property (@(posedge clk) disable iff (rst)
        seen_rst && nop_on |-> !sram_sel && !xcvr_en); // R2

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        seen_rst && !cpu_rw |-> !cpu_doe); // R3

    AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        seen_rst && !$past(rst) |-> nop_on == $past(nop_req)); // R4

    AST_VEC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        seen_rst && armed && !cpu_reset && cpu_rw && cpu_addr == VEC_HI |=> !armed); // R6

    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        seen_rst && cpu_doe |-> !sram_sel && !xcvr_en); // R7

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        seen_rst && !nop_on && !vec_hit |-> sram_sel == sram_sel_in && xcvr_en == xcvr_en_in && !cpu_doe); // R8

endmodule

bind nop_inject_unit nop_inject_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NOP_CODE (NOP_CODE),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nop_req     (nop_req),
    .cpu_reset   (cpu_reset),
    .cpu_addr    (cpu_addr),
    .cpu_rw      (cpu_rw),
    .sram_sel_in (sram_sel_in),
    .xcvr_en_in  (xcvr_en_in),
    .cpu_dout    (cpu_dout),
    .cpu_doe     (cpu_doe),
    .sram_sel    (sram_sel),
    .xcvr_en     (xcvr_en),
    .nop_on      (nop_on),
    .armed       (armed),
    .vec_hit     (vec_hit)
);

// File: tb/sim_nop_inject_unit.sv
module sim_nop_inject_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nop_req = 1'b0;
    logic        vec_enable = 1'b0;
    logic        vec_load = 1'b0;
    logic [15:0] vec_word = 16'h0;
    logic        cpu_reset = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        cpu_rw = 1'b1;
    logic        sram_sel_in = 1'b0;
    logic        xcvr_en_in = 1'b0;
    logic [7:0]  cpu_dout;
    logic        cpu_doe;
    logic        sram_sel;
    logic        xcvr_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state after the most recent edge
    bit        m_nop   = 1'b0;
    bit        m_armed = 1'b0;
    bit [15:0] m_vec   = 16'h0;

    always #10 clk = ~clk;

    nop_inject_unit u0 (
        .clk(clk), .rst(rst), .nop_req(nop_req), .vec_enable(vec_enable),
        .vec_load(vec_load), .vec_word(vec_word), .cpu_reset(cpu_reset),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .sram_sel_in(sram_sel_in),
        .xcvr_en_in(xcvr_en_in), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
        .sram_sel(sram_sel), .xcvr_en(xcvr_en)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s addr=%h rw=%0b actual=%h expected=%h",
                     tag, what, cpu_addr, cpu_rw, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, compare just before the rising edge
    task automatic cyc(input bit r, input bit nr, input bit ven, input bit vld,
                       input logic [15:0] vw, input bit cr, input logic [15:0] a,
                       input bit rw, input bit si, input bit xi);
        bit       vhit;
        bit [7:0] e_dout;
        bit       e_doe, e_sram, e_xcvr;
        string    tag;
        @(negedge clk);
        rst = r; nop_req = nr; vec_enable = ven; vec_load = vld; vec_word = vw;
        cpu_reset = cr; cpu_addr = a; cpu_rw = rw; sram_sel_in = si; xcvr_en_in = xi;
        #8;
        vhit = m_armed && !cr && rw && (a == 16'hFFFC || a == 16'hFFFD);
        if (vhit) begin
            tag = "R5"; e_doe = 1'b1; e_dout = a[0] ? m_vec[15:8] : m_vec[7:0];
            e_sram = 1'b0; e_xcvr = 1'b0;
        end else if (m_nop) begin
            tag = rw ? "R1" : "R3"; e_doe = rw; e_dout = rw ? 8'hEA : 8'h00;
            e_sram = 1'b0; e_xcvr = 1'b0;
        end else begin
            tag = "R8"; e_doe = 1'b0; e_dout = 8'h00; e_sram = si; e_xcvr = xi;
        end
        check(tag, "doe", {15'd0, cpu_doe}, {15'd0, e_doe});
        check(tag, "dout", {8'd0, cpu_dout}, {8'd0, e_dout});
        check(vhit ? "R7" : (m_nop ? "R2" : "R8"), "sram_sel", {15'd0, sram_sel}, {15'd0, e_sram});
        check(vhit ? "R7" : (m_nop ? "R2" : "R8"), "xcvr_en", {15'd0, xcvr_en}, {15'd0, e_xcvr});
        // Next state (R4 sampling, R6 arming, R9 reset, R10 writes ignored)
        if (r) begin
            m_nop = 1'b0; m_armed = 1'b0; m_vec = 16'h0;
        end else begin
            m_nop = nr;
            if (vld) m_vec = vw;
            if (cr) m_armed = ven;
            else if (vhit && a[0]) m_armed = 1'b0;
        end
    endtask

    initial begin
        // Reset; outputs are pass-through with no drive afterwards (R9)
        cyc(1, 0, 0, 0, 16'h0, 0, 16'h0000, 1, 0, 0);
        cyc(1, 1, 1, 1, 16'hBEEF, 1, 16'h1000, 1, 1, 0);
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 1);   // R9: not armed, vector 0
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFD, 1, 0, 1);

        // Pass-through patterns (R8)
        for (int i = 0; i < 16; i++)
            cyc(0, 0, 0, 0, 16'h0, 0, 16'(i * 16'h1111), i[0], i[1], i[2]);

        // NOP on mid-stream; first cycle still old mode (R4)
        cyc(0, 1, 0, 0, 16'h0, 0, 16'h2000, 1, 1, 1);
        for (int a = 16'hE7F8; a < 16'hF010; a += 8)     // R2 sweep over I/O window
            cyc(0, 1, 0, 0, 16'h0, 0, 16'(a), (a % 24) != 0, 1, 1);
        cyc(0, 1, 0, 0, 16'h0, 0, 16'hE810, 0, 1, 1);   // R3 write in I/O window
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hE811, 1, 1, 1);   // R4: still NOP this cycle
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hE812, 1, 1, 1);   // R4: now pass-through

        // Vector override: load, hold reset, release (R5, R6)
        cyc(0, 0, 0, 1, 16'h1234, 1, 16'h0000, 1, 0, 0);
        cyc(0, 0, 1, 0, 16'h0, 1, 16'hFFFC, 1, 1, 1);   // in reset: pass-through
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 0, 1, 1);   // R10 write not overridden
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFD, 0, 1, 0);   // R10 write does not disarm
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 1);   // R5 low byte
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 1);   // R6 repeat low still armed
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFD, 1, 1, 1);   // R5 high byte, disarms
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFD, 1, 1, 0);   // R6 passes through now
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 1, 0, 1);

        // Override with NOP active: vector wins (R7)
        cyc(0, 1, 1, 1, 16'hC0DE, 1, 16'h0000, 1, 0, 0);
        cyc(0, 1, 1, 0, 16'h0, 1, 16'hFFFC, 1, 1, 1);
        cyc(0, 1, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 1);
        cyc(0, 1, 0, 0, 16'h0, 0, 16'hFFFD, 1, 1, 1);
        cyc(0, 1, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 1);   // back to EA (R1)

        // Reset held with enable low leaves it disarmed (R6)
        cyc(0, 0, 1, 0, 16'h0, 1, 16'h0000, 1, 0, 0);
        cyc(0, 0, 0, 0, 16'h0, 1, 16'h0000, 1, 0, 0);
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFC, 1, 1, 0);
        cyc(0, 0, 0, 0, 16'h0, 0, 16'hFFFD, 1, 0, 1);

        // Mixed random traffic biased toward the vector pair
        for (int i = 0; i < 4000; i++) begin
            automatic logic [15:0] a = ($urandom % 4 == 0) ? (16'hFFFC | 16'($urandom % 2)) : 16'($urandom);
            cyc(($urandom % 97) == 0, ($urandom % 5) < 2, $urandom % 2, ($urandom % 7) == 0,
                16'($urandom), ($urandom % 11) == 0, a, ($urandom % 4) != 0,
                $urandom % 2, $urandom % 2);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule